// File: doc/BRIEF.md
# Sliding-Window Cell Header Check Unit

This block watches a byte-wide cell stream that delivers one byte on every clock. It keeps the most recent bytes in a short chain of byte registers. On every rising edge it asks whether the byte now arriving is the correct check byte for the four bytes just before it. The check byte is a CRC-8 of those four bytes with a fixed coset added. When the answer is yes, the block raises a one-cycle match flag.

The test runs at every byte offset, not only at a known cell boundary. A framing controller placed downstream can therefore count matches and lock onto the cell boundary at whatever alignment the stream arrives with.

The same register chain is the stream's delay line. Bytes leave on the output five stages after entry. The cycle in which the flag rises is the cycle in which the first header byte of the matching window sits on the output, so downstream logic sees the flag and the start of the cell together.

Top module: `hec_window_checker`

## Requirements
- R1: A rising edge with `rst_n` low clears every delay stage and the match flag, so `dout` is 0x00 and `match` is 0 in the following cycle.
- R2: The byte sampled on `din` at a rising edge appears on `dout` after four further rising edges, and stays there for one cycle.
- R3: The expected check byte is a CRC-8 with generator x^8+x^2+x+1 (0x07). It starts from zero and processes the bits most significant bit first. It covers the four header bytes with the oldest byte first, and its result is XORed with 0x55.
- R4: `match` is 1 in the cycle after an edge exactly when the byte sampled at that edge equals the R3 check byte of the four bytes sampled at the four edges before it. In that cycle `dout` carries the oldest of those four header bytes.
- R5: The comparison is made at every edge, so a header is detected at any byte offset. This includes headers that directly follow filler bytes and cells that follow one another.
- R6: A window whose check byte or header has a single bit flipped gives `match` 0, as does any window whose last byte differs from its R3 check byte.
- R7: After a match, `dout` presents the second, third and fourth header bytes and then the check byte, on the four consecutive following cycles.
- R8: Bytes received before a reset take no part in later windows. Directly after reset the window holds zero bytes, so an arriving 0x55 produces a match and a check byte computed for a header sent before the reset does not produce one, unless it happens to equal 0x55.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock, one stream byte per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 8 | Incoming stream byte |
| dout | output | 8 | Stream byte delayed by the five-stage chain |
| match | output | 1 | Registered flag: the last five bytes form a valid header |

## Verification
A wrong stage in the chain shows on `dout` within five cycles as a byte that is out of order or corrupted. Because that stage also feeds the CRC, it also shows as a missing or spurious `match` pulse when the next header passes. A fault in the check computation appears only at the flag, so directed headers, single-bit corruptions and a long randomised stream with headers placed at varied offsets compare `match` on every cycle. A stale window after reset is exposed on the first check byte that follows the reset.

// File: rtl/hec_chk_pkg.sv
package hec_chk_pkg;

   // Implementation variants for the check-byte generator.
   typedef enum logic [0:0] {
      CRC_SERIAL = 1'b0,   // bit-at-a-time unrolled shift register
      CRC_MATRIX = 1'b1    // precomputed XOR mask per output bit
   } crc_style_e;

   localparam int unsigned DEF_DATA_W    = 8;
   localparam int unsigned DEF_HDR_BYTES = 4;
   localparam logic [7:0]  DEF_POLY      = 8'h07;
   localparam logic [7:0]  DEF_COSET     = 8'h55;

endpackage

// File: rtl/hec_window_shift.sv
module hec_window_shift #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 5
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [DATA_W-1:0]            din,
   output logic [DEPTH-1:0][DATA_W-1:0] taps
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("hec_window_shift: DEPTH must be at least 2");
      end
   endgenerate

   // Stage 0 takes the newest byte; stage DEPTH-1 holds the oldest.
   always_ff @(posedge clk) begin
      if (!rst_n) taps[0] <= '0;
      else        taps[0] <= din;
   end

   generate
      for (genvar s = 1; s < DEPTH; s++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) taps[s] <= '0;
            else        taps[s] <= taps[s-1];
         end

         // R2: each stage takes over its upstream neighbour one edge later
         a_r2_stage_shift : assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> taps[s] == $past(taps[s-1]));
      end
   endgenerate

   // R2: the entry stage captures the input byte
   a_r2_entry_capture : assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> taps[0] == $past(din));

   // R1: the cycle after a reset edge sees a cleared chain
   a_r1_chain_cleared : assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> taps == '0);

endmodule

// File: rtl/hec_crc_calc.sv
module hec_crc_calc
   import hec_chk_pkg::*;
#(
   parameter int unsigned       DATA_W    = 8,
   parameter int unsigned       HDR_BYTES = 4,
   parameter logic [DATA_W-1:0] POLY      = 'h07,
   parameter logic [DATA_W-1:0] COSET     = 'h55,
   parameter crc_style_e        STYLE     = CRC_MATRIX
) (
   // Header bytes, oldest byte in the most significant position.
   input  logic [HDR_BYTES*DATA_W-1:0] hdr_flat,
   output logic [DATA_W-1:0]           hec_exp
);

   localparam int unsigned MSG_W = HDR_BYTES * DATA_W;

   logic [DATA_W-1:0] raw_crc;

   // Division of the message by the generator, one message bit per step.
   function automatic logic [DATA_W-1:0] serial_crc(input logic [MSG_W-1:0] msg);
      logic [DATA_W-1:0] c;
      logic              fb;
      c = '0;
      for (int i = MSG_W - 1; i >= 0; i--) begin
         fb = c[DATA_W-1] ^ msg[i];
         c  = {c[DATA_W-2:0], 1'b0};
         if (fb) c = c ^ POLY;
      end
      return c;
   endfunction

   // Mask of message bits that feed output bit j (the CRC is linear, zero init).
   function automatic logic [MSG_W-1:0] row_mask(input int unsigned j);
      logic [MSG_W-1:0]  m;
      logic [MSG_W-1:0]  unit;
      logic [DATA_W-1:0] col;
      m = '0;
      for (int i = 0; i < MSG_W; i++) begin
         unit    = '0;
         unit[i] = 1'b1;
         col     = serial_crc(unit);
         m[i]    = col[j];
      end
      return m;
   endfunction

   generate
      if (STYLE == CRC_SERIAL) begin : g_serial
         always_comb raw_crc = serial_crc(hdr_flat);
      end else begin : g_matrix
         for (genvar j = 0; j < DATA_W; j++) begin : g_bit
            localparam logic [MSG_W-1:0] MASK = row_mask(j);
            assign raw_crc[j] = ^(hdr_flat & MASK);
         end
      end
   endgenerate

   assign hec_exp = raw_crc ^ COSET;

   // R3: all-zero header yields the coset alone
   always_comb begin
      if (hdr_flat == '0) a_r3_zero_window : assert (hec_exp == COSET);
   end

endmodule

// File: rtl/hec_match_reg.sv
module hec_match_reg #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic [DATA_W-1:0] exp_byte,
   output logic              match
);

   always_ff @(posedge clk) begin
      if (!rst_n) match <= 1'b0;
      else        match <= (rx_byte == exp_byte);
   end

   // R1: the flag is low in the cycle after a reset edge
   a_r1_flag_cleared : assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> !match);

endmodule

// File: rtl/hec_window_checker.sv
module hec_window_checker
   import hec_chk_pkg::*;
#(
   parameter int unsigned       DATA_W    = DEF_DATA_W,
   parameter int unsigned       HDR_BYTES = DEF_HDR_BYTES,
   parameter logic [DATA_W-1:0] POLY      = DEF_POLY,
   parameter logic [DATA_W-1:0] COSET     = DEF_COSET,
   parameter crc_style_e        CRC_STYLE = CRC_MATRIX
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              match
);

   localparam int unsigned DEPTH = HDR_BYTES + 1;
   localparam int unsigned MSG_W = HDR_BYTES * DATA_W;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("hec_window_checker: DATA_W must be at least 2");
      end
      if (HDR_BYTES < 1) begin : g_bad_hdr
         $error("hec_window_checker: HDR_BYTES must be at least 1");
      end
      if (POLY[0] != 1'b1) begin : g_bad_poly
         $error("hec_window_checker: generator must have a constant term");
      end
   endgenerate

   logic [DEPTH-1:0][DATA_W-1:0] taps;
   logic [MSG_W-1:0]             hdr_flat;
   logic [DATA_W-1:0]            hec_exp;

   hec_window_shift #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (din),
      .taps  (taps)
   );

   // Before the edge, taps[HDR_BYTES-1:0] hold the four header candidates.
   assign hdr_flat = taps[HDR_BYTES-1:0];

   hec_crc_calc #(
      .DATA_W    (DATA_W),
      .HDR_BYTES (HDR_BYTES),
      .POLY      (POLY),
      .COSET     (COSET),
      .STYLE     (CRC_STYLE)
   ) u_crc (
      .hdr_flat (hdr_flat),
      .hec_exp  (hec_exp)
   );

   hec_match_reg #(
      .DATA_W (DATA_W)
   ) u_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_byte  (din),
      .exp_byte (hec_exp),
      .match    (match)
   );

   assign dout = taps[DEPTH-1];

   // Independent byte-at-a-time formulation used only by the assertions.
   function automatic logic [DATA_W-1:0] bytewise_hec(
      input logic [HDR_BYTES-1:0][DATA_W-1:0] h);
      logic [DATA_W-1:0] c;
      c = '0;
      for (int k = HDR_BYTES - 1; k >= 0; k--) begin
         c = c ^ h[k];
         for (int s = 0; s < DATA_W; s++) begin
            if (c[DATA_W-1]) c = {c[DATA_W-2:0], 1'b0} ^ POLY;
            else             c = {c[DATA_W-2:0], 1'b0};
         end
      end
      return c ^ COSET;
   endfunction

   // R4: a raised flag means the stored window is a valid header
   a_r4_flag_window_valid : assert property (@(posedge clk) disable iff (!rst_n)
      match |-> taps[0] == bytewise_hec(taps[HDR_BYTES:1]));

   // R4: a valid stored window after a normal edge raises the flag
   a_r4_window_raises_flag : assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && taps[0] == bytewise_hec(taps[HDR_BYTES:1])) |-> match);

   // R7: the second header byte follows the first on the output
   a_r7_next_header_byte : assert property (@(posedge clk) disable iff (!rst_n)
      match |=> dout == $past(taps[DEPTH-2]));

endmodule

// File: tb/hec_window_checker_tb.sv
module hec_window_checker_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] din = 8'h00;
   logic [7:0] dout;
   logic       match;

   always #5 clk = ~clk;

   hec_window_checker dut_i (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (din),
      .dout  (dout),
      .match (match)
   );

   int unsigned n_chk = 0;
   int unsigned n_fail = 0;
   bit          done = 1'b0;

   // Bench model: m_w[0] newest sampled byte, m_w[4] the one on dout.
   logic [4:0][7:0] m_w = '0;
   logic            m_match = 1'b0;

   // R3 reference: shift-register division, bit by bit, coset added.
   function automatic logic [7:0] ref_hec(input logic [7:0] a, input logic [7:0] b,
                                          input logic [7:0] c, input logic [7:0] d);
      logic [31:0] msg;
      logic [7:0]  r;
      logic        fb;
      msg = {a, b, c, d};
      r = 8'h00;
      for (int i = 31; i >= 0; i--) begin
         fb = r[7] ^ msg[i];
         r  = r << 1;
         if (fb) r = r ^ 8'h07;
      end
      return r ^ 8'h55;
   endfunction

   task automatic chk8(input logic [7:0] act, input logic [7:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: dout actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic chk1(input logic act, input logic exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: match actual %0b expected %0b", tag, act, exp);
      end
   endtask

   // Called at a falling edge: compare outputs to model, drive the next byte.
   task automatic push(input logic [7:0] b, input string tag);
      chk8(dout, m_w[4], tag);
      chk1(match, m_match, tag);
      din = b;
      m_match = (b == ref_hec(m_w[3], m_w[2], m_w[1], m_w[0]));
      for (int i = 4; i > 0; i--) m_w[i] = m_w[i-1];
      m_w[0] = b;
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      din   = 8'hFF;
      @(negedge clk);
      m_w = '0;
      m_match = 1'b0;
      chk8(dout, 8'h00, "R1 reset clears chain");
      chk1(match, 1'b0, "R1 reset clears flag");
      rst_n = 1'b1;
   endtask

   task automatic send_header(input logic [7:0] h1, input logic [7:0] h2,
                              input logic [7:0] h3, input logic [7:0] h4, input string tag);
      logic [7:0] hec;
      hec = ref_hec(h1, h2, h3, h4);
      push(h1, tag); push(h2, tag); push(h3, tag); push(h4, tag); push(hec, tag);
   endtask

   task automatic t_reset();
      do_reset();
   endtask

   task automatic t_delay();
      push(8'hA1, "R2"); push(8'hB2, "R2"); push(8'hC3, "R2");
      push(8'hD4, "R2"); push(8'hE5, "R2");
      chk8(dout, 8'hA1, "R2 byte out after five stages");
      push(8'h00, "R2");
      chk8(dout, 8'hB2, "R2 next byte in order");
   endtask

   task automatic t_known(input logic [7:0] h1, input logic [7:0] h2,
                          input logic [7:0] h3, input logic [7:0] h4);
      logic [7:0] hec;
      hec = ref_hec(h1, h2, h3, h4);
      send_header(h1, h2, h3, h4, "R3 header");
      chk1(match, 1'b1, "R4 flag on check byte");
      chk8(dout, h1, "R4 first header byte aligned with flag");
      push(8'h6A, "R7");
      chk8(dout, h2, "R7 second header byte");
      push(8'h6A, "R7");
      chk8(dout, h3, "R7 third header byte");
      push(8'h6A, "R7");
      chk8(dout, h4, "R7 fourth header byte");
      push(8'h6A, "R7");
      chk8(dout, hec, "R7 check byte last");
   endtask

   task automatic t_listed_sequences();
      push(8'hAA, "R6"); push(8'h84, "R6"); push(8'h74, "R6"); push(8'h00, "R6"); push(8'h00, "R6");
      push(8'h00, "R6"); push(8'h99, "R6"); push(8'hE4, "R6"); push(8'hAB, "R6"); push(8'h00, "R6");
      push(8'hAB, "R6"); push(8'hE4, "R6"); push(8'h99, "R6"); push(8'h00, "R6"); push(8'h00, "R6");
      push(8'h3C, "R6");
   endtask

   task automatic t_bit_flips();
      logic [7:0] hec;
      hec = ref_hec(8'h11, 8'h22, 8'h33, 8'h44);
      push(8'h11, "R6"); push(8'h22, "R6"); push(8'h33, "R6"); push(8'h44, "R6");
      push(hec ^ 8'h01, "R6");
      chk1(match, 1'b0, "R6 flipped check bit");
      push(8'h11, "R6"); push(8'h32, "R6"); push(8'h33, "R6"); push(8'h44, "R6");
      push(hec, "R6");
      chk1(match, 1'b0, "R6 flipped header bit");
   endtask

   task automatic t_alignment();
      for (int off = 0; off < 7; off++) begin
         for (int k = 0; k < off; k++) push(8'(8'h90 + k * 8'h13), "R5 filler");
         send_header(8'(off), 8'(8'h40 + off), 8'hC1, 8'(8'h07 * off), "R5");
         chk1(match, 1'b1, "R5 match at varied offset");
      end
      send_header(8'h82, 8'hFF, 8'hDD, 8'hCC, "R5");
      chk1(match, 1'b1, "R5 first of consecutive cells");
      send_header(8'h12, 8'h34, 8'h56, 8'h78, "R5");
      chk1(match, 1'b1, "R5 second of consecutive cells");
   endtask

   task automatic t_reset_midstream();
      logic [7:0] hec;
      hec = ref_hec(8'h11, 8'h22, 8'h33, 8'h44);
      push(8'h11, "R8"); push(8'h22, "R8"); push(8'h33, "R8"); push(8'h44, "R8");
      do_reset();
      push(hec, "R8");
      chk1(match, hec == 8'h55, "R8 stale header ignored after reset");
      chk8(dout, 8'h00, "R8 chain holds zeros");
      do_reset();
      push(8'h55, "R8");
      chk1(match, 1'b1, "R8 zero window matches 0x55");
   endtask

   task automatic t_random();
      logic [7:0] a, b, c, d;
      for (int n = 0; n < 40; n++) begin
         for (int k = 0; k < int'(n % 9); k++) push(8'($urandom), "R5 random");
         a = 8'($urandom); b = 8'($urandom); c = 8'($urandom); d = 8'($urandom);
         send_header(a, b, c, d, "R5 random");
         chk1(match, 1'b1, "R5 random header");
      end
      push(8'h00, "R5 random");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_delay();
      t_known(8'h11, 8'h22, 8'h33, 8'h44);
      t_known(8'h82, 8'hFF, 8'hDD, 8'hCC);
      t_known(8'h00, 8'h01, 8'h02, 8'h03);
      t_listed_sequences();
      t_bit_flips();
      t_alignment();
      t_reset_midstream();
      t_random();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule